// File: doc/BRIEF.md
# Microprogrammed Multiplier Sequencer

This block steps a fixed ten-word microprogram that drives a shift-and-add two's complement multiplier datapath. Each stored word carries a 2-bit test code, a 4-bit jump target and thirteen control bits. The thirteen bits are twelve datapath strobes, called c0 to c11 here, and a completion flag. The word being executed sits in a registered microinstruction holder, and its strobes go straight to the datapath. The next word address is either the current address plus one or the jump target. The test code picks which of these is used: never jump, jump when the multiplier LSB is low, jump when the last-count flag is low, or always jump.

The block has two named states. **ST_IDLE** is entered on reset. In this state every output is low and the block waits for `start`. The transition **IDLE→RUN** happens on a clock edge with `start` high, and it loads word 0. In **ST_RUN** one word is executed per clock. The transition **RUN→RUN (step)** takes the jump target or the next address. The transition **RUN→RUN (restart)** happens when `start` is high while the completion word is held, and it reloads word 0. Reset is the only way back to ST_IDLE.

Word layout by address:

| Address | Strobes | Test | Target |
|---|---|---|---|
| 0 | c9, c10 | never | – |
| 1 | c8 | never | – |
| 2 | none | LSB low | 4 |
| 3 | c2, c3, c4 | never | – |
| 4 | c0, c1, c11 | count low | 2 |
| 5 | none | LSB low | 7 |
| 6 | c2, c3, c4, c5 | never | – |
| 7 | c6 | never | – |
| 8 | c7 | never | – |
| 9 | completion flag | always | 9 |

Top module: `mseq_top`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it is released, `ctl_o` is zero and `done_o` is low.
- R2: In ST_IDLE every output is zero. The block stays in ST_IDLE until a clock edge that sees `start` high.
- R3: The cycle after that edge, `ctl_o` shows c9 and c10 (12'h600). The cycle after that, it shows only c8 (12'h100).
- R4: The cycle after word 2, the block shows word 3 (c2 to c4, 12'h01C) if `q_lsb` was 1 during word 2. If `q_lsb` was 0, it shows word 4 (c0, c1, c11, 12'h803). Word 3 is always followed by word 4.
- R5: After word 4, the block shows word 2 (all outputs zero) if `cnt_last` was 0 during word 4. If `cnt_last` was 1, it shows word 5 (all outputs zero).
- R6: After word 5, the block shows word 6 (c2 to c5, 12'h03C) if `q_lsb` was 1 during word 5. If `q_lsb` was 0, it shows word 7 (c6, 12'h040). Word 6 is always followed by word 7.
- R7: Word 7 is followed by word 8 (c7, 12'h080), and word 8 is followed by the completion word.
- R8: In the completion word, `done_o` is 1 and `ctl_o` is zero. The word repeats every cycle until a clock edge with `start` high, and the next cycle then shows word 0.
- R9: `start` has no effect in any running word other than the completion word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin, or restart from the completion word |
| q_lsb | input | 1 | Multiplier register LSB from the datapath |
| cnt_last | input | 1 | High when the iteration counter reaches its last value |
| ctl_o | output | 12 | Datapath strobes; bit i is ci |
| done_o | output | 1 | Completion flag |

## Verification
The bench drives `q_lsb` and `cnt_last` with seeded random values each cycle. A low `cnt_last` probability gives long add/shift loops, so both branches of each LSB test are taken many times. `start` pulses arrive at random times: in ST_IDLE they separate waiting from launching, in running words they show that `start` is ignored, and in the completion word they show the restart. A directed reset during a run checks that the block returns to a quiet ST_IDLE.

// File: rtl/mseq_pkg.sv
package mseq_pkg;
    localparam int ADDR_W  = 4;
    localparam int STRB_W  = 12;
    localparam int CTRL_W  = STRB_W + 1;
    localparam int DONE_B  = STRB_W;
    localparam int WORDS   = 10;

    typedef enum logic [1:0] {
        SEL_NEVER  = 2'b00,
        SEL_QLOW   = 2'b01,
        SEL_CNTLOW = 2'b10,
        SEL_ALWAYS = 2'b11
    } sel_e;

    typedef struct packed {
        sel_e              sel;
        logic [ADDR_W-1:0] br;
        logic [CTRL_W-1:0] ctl;
    } uword_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } seq_state_e;
endpackage

// File: rtl/mseq_store.sv
module mseq_store
    import mseq_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output uword_t            word
);
    always_comb begin
        word = '0;
        if (int'(addr) < WORDS) begin
            unique case (addr)
                4'd0:    word = '{sel: SEL_NEVER,  br: 4'd0, ctl: 13'h0600};
                4'd1:    word = '{sel: SEL_NEVER,  br: 4'd0, ctl: 13'h0100};
                4'd2:    word = '{sel: SEL_QLOW,   br: 4'd4, ctl: 13'h0000};
                4'd3:    word = '{sel: SEL_NEVER,  br: 4'd0, ctl: 13'h001C};
                4'd4:    word = '{sel: SEL_CNTLOW, br: 4'd2, ctl: 13'h0803};
                4'd5:    word = '{sel: SEL_QLOW,   br: 4'd7, ctl: 13'h0000};
                4'd6:    word = '{sel: SEL_NEVER,  br: 4'd0, ctl: 13'h003C};
                4'd7:    word = '{sel: SEL_NEVER,  br: 4'd0, ctl: 13'h0040};
                4'd8:    word = '{sel: SEL_NEVER,  br: 4'd0, ctl: 13'h0080};
                4'd9:    word = '{sel: SEL_ALWAYS, br: 4'd9, ctl: 13'h1000};
                default: word = '0;
            endcase
        end
    end
endmodule

// File: rtl/mseq_cond.sv
module mseq_cond
    import mseq_pkg::*;
(
    input  sel_e sel,
    input  logic q_lsb,
    input  logic cnt_last,
    output logic take
);
    always_comb begin
        unique case (sel)
            SEL_NEVER:  take = 1'b0;
            SEL_QLOW:   take = !q_lsb;
            SEL_CNTLOW: take = !cnt_last;
            SEL_ALWAYS: take = 1'b1;
            default:    take = 1'b0;
        endcase
    end
endmodule

// File: rtl/mseq_top.sv
module mseq_top
    import mseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              q_lsb,
    input  logic              cnt_last,
    output logic [STRB_W-1:0] ctl_o,
    output logic              done_o
);
    seq_state_e        state, nxt_state;
    logic [ADDR_W-1:0] pc, nxt_pc;
    uword_t            uir, fetched;
    logic              take;

    mseq_cond u_cond (
        .sel      (uir.sel),
        .q_lsb    (q_lsb),
        .cnt_last (cnt_last),
        .take     (take)
    );

    mseq_store u_store (
        .addr (nxt_pc),
        .word (fetched)
    );

    // next-state and next-address logic
    always_comb begin
        nxt_state = state;
        nxt_pc    = pc;
        unique case (state)
            ST_IDLE: begin
                nxt_pc = '0;
                if (start) nxt_state = ST_RUN;
            end
            ST_RUN: begin
                if (uir.ctl[DONE_B] && start) nxt_pc = '0;
                else if (take)                nxt_pc = uir.br;
                else                          nxt_pc = pc + ADDR_W'(1);
            end
            default: nxt_state = ST_IDLE;
        endcase
    end

    // state, counter and microinstruction register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            pc    <= '0;
            uir   <= '0;
        end else begin
            state <= nxt_state;
            pc    <= nxt_pc;
            uir   <= (nxt_state == ST_RUN) ? fetched : '0;
        end
    end

    // outputs
    always_comb begin
        ctl_o  = uir.ctl[STRB_W-1:0];
        done_o = uir.ctl[DONE_B];
    end

    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (ctl_o == '0 && !done_o));

    assert_entry_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && start) |=> (ctl_o == 12'h600 && !done_o));

    assert_loop_back_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_o[11] && !cnt_last) |=> (ctl_o == '0 && !done_o));

    assert_out_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_o[6] |=> (ctl_o == 12'h080));

    assert_end_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start) |=> done_o);

    assert_end_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (ctl_o == '0));

    assert_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && start) |=> (ctl_o == 12'h600));
endmodule

// File: tb/sim_mseq_top.sv
`timescale 1ns/1ps
module sim_mseq_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        q_lsb = 1'b0;
    logic        cnt_last = 1'b0;
    logic [11:0] ctl_o;
    logic        done_o;

    int checks = 0;
    int fails  = 0;

    bit m_run = 0;
    int m_addr = 0;
    bit m_ign = 0;

    always #2.5 clk = ~clk;

    mseq_top u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .q_lsb(q_lsb),
        .cnt_last(cnt_last), .ctl_o(ctl_o), .done_o(done_o)
    );

    function automatic logic [11:0] exp_strb(input int a);
        case (a)
            0: return 12'h600;
            1: return 12'h100;
            3: return 12'h01C;
            4: return 12'h803;
            6: return 12'h03C;
            7: return 12'h040;
            8: return 12'h080;
            default: return 12'h000;
        endcase
    endfunction

    function automatic int flow_next(input int a, input bit q, input bit c);
        case (a)
            2: return q ? 3 : 4;
            4: return c ? 5 : 2;
            5: return q ? 6 : 7;
            9: return 9;
            default: return a + 1;
        endcase
    endfunction

    function automatic string req_of(input bit run, input int a, input bit ign);
        if (ign) return "R9";
        if (!run) return "R2";
        case (a)
            0, 1: return "R3";
            2, 3: return "R4";
            4: return "R5";
            5, 6: return "R6";
            7, 8: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic check(input string req, input logic [11:0] ec, input logic ed);
        checks++;
        if (ctl_o !== ec || done_o !== ed) begin
            fails++;
            $display("FAIL %s: ctl=%h done=%b expected ctl=%h done=%b",
                     req, ctl_o, done_o, ec, ed);
        end
    endtask

    task automatic check_model();
        logic [11:0] ec;
        logic ed;
        ec = m_run ? exp_strb(m_addr) : 12'h000;
        ed = m_run && (m_addr == 9);
        check(req_of(m_run, m_addr, m_ign), ec, ed);
    endtask

    // advance the model for the edge that follows
    task automatic step_model();
        m_ign = 0;
        if (!m_run) begin
            if (start) begin m_run = 1; m_addr = 0; end
        end else if (m_addr == 9 && start) begin
            m_addr = 0;
        end else begin
            if (start) m_ign = 1;
            m_addr = flow_next(m_addr, q_lsb, cnt_last);
        end
    endtask

    task automatic drive(input int pstart, input int pcnt);
        start    = (($urandom % 100) < pstart);
        q_lsb    = $urandom % 2;
        cnt_last = (($urandom % 100) < pcnt);
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        check("R1", 12'h000, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", 12'h000, 1'b0);
        // idle with start low stays quiet (R2)
        repeat (4) begin
            step_model();
            @(negedge clk);
            check_model();
        end
        // directed: LSB low at both tests, one loop then exit
        start = 1; step_model(); @(negedge clk); check_model(); start = 0;
        for (int i = 0; i < 12; i++) begin
            q_lsb = 0; cnt_last = (i == 5);
            step_model(); @(negedge clk); check_model();
        end
        // random run
        for (int i = 0; i < 4000; i++) begin
            drive(15, 20);
            step_model();
            @(negedge clk);
            check_model();
            if (i == 2000) begin
                rst_n = 1'b0;
                #1;
                check("R1", 12'h000, 1'b0);
                m_run = 0; m_addr = 0; m_ign = 0;
                @(negedge clk);
                check("R1", 12'h000, 1'b0);
                start = 0;
                rst_n = 1'b1;
                @(negedge clk);
                check("R1", 12'h000, 1'b0);
            end
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #500000;
        fails++;
        checks++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule